// File: doc/BRIEF.md
# Virtual Alias Scrubber for a Virtually Indexed, Physically Tagged Cache

This block cleans up virtual aliases in a cache that is indexed with virtual address bits but tagged with physical address bits. With 8 KB pages, 64-byte lines and 512 sets, the set index is VA[14:6]. Its low seven bits, VA[12:6], come from the page offset, so they are the same in every virtual address that maps to a given physical line. The two high index bits, VA[14:13], come from the virtual page number and can differ between aliases. A physical line can therefore sit in any of four sets that share the low index bits. Each stored tag holds physical address bits [63:13], which lets the block recognize the same physical line wherever it is held.

When a miss occurs, the miss handler gives the block the missing access's virtual index and the physical tag that translation returned, then pulses start. The block visits the four candidate sets in increasing order of the high index bits, one set per cycle, and compares all four ways in parallel. Every valid way whose tag equals the requested one is invalidated. A dirty match is first presented on a valid/ready writeback channel. It is cleared only in the cycle its handshake completes, and the walk waits while the channel is back-pressured. When the last set has been handled, done pulses and the refill may write its line through the fill port.

The tag array (valid, dirty and tag for each way of each set) lives inside the block. It is loaded through the fill port and can be read back through a combinational probe port.

Top module: `alias_scrub`

## Requirements
- R1: After reset, busy_o, done_o and wb_valid_o are 0 and every entry reads back as invalid and clean on the probe port.
- R2: A fill_en_i pulse while busy_o is 0 writes the addressed entry as valid, with fill_ptag_i and fill_dirty_i, and the probe port shows it from the next cycle. A fill pulse while busy_o is 1 is ignored.
- R3: A start_i pulse while idle raises busy_o from the next cycle until the walk ends. A start_i pulse while busy_o is 1 is ignored and does not trigger a second walk.
- R4: For each k from 0 to 3, the walk visits set index {k[1:0], miss_vidx_i[6:0]}, taking k in ascending order. Bits [8:7] of miss_vidx_i have no effect, and a writeback from a lower k always comes before one from a higher k.
- R5: In the visited sets, every valid clean way whose tag equals miss_ptag_i becomes invalid. Ways with a different tag and entries in all other sets keep their contents.
- R6: A valid dirty way whose tag matches is reported with wb_valid_o=1, wb_set_o (its set), wb_way_o (its way) and wb_ptag_o (its tag). It is cleared to invalid and clean in the cycle wb_ready_i is 1 with wb_valid_o.
- R7: While wb_valid_o is 1 and wb_ready_i is 0, wb_valid_o stays 1 and wb_set_o, wb_way_o and wb_ptag_o stay unchanged. The walk does not advance.
- R8: If one set holds several dirty matches, they are reported one handshake at a time, lowest way number first.
- R9: done_o is 1 for exactly one cycle, the first cycle busy_o is 0 after a walk. A walk with no dirty matches keeps busy_o high for exactly 4 cycles.
- R10: An invalid way whose stale tag equals miss_ptag_i produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Launch pulse for an alias walk |
| miss_vidx_i | input | 9 | Virtual set index of the missing access |
| miss_ptag_i | input | 51 | Physical tag of the missing line (PA[63:13]) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk completes |
| wb_valid_o | output | 1 | Writeback request for a dirty alias |
| wb_ready_i | input | 1 | Writeback sink accepts the request |
| wb_set_o | output | 9 | Set of the dirty alias |
| wb_way_o | output | 2 | Way of the dirty alias |
| wb_ptag_o | output | 51 | Tag of the dirty alias |
| fill_en_i | input | 1 | Write one tag entry (refill) |
| fill_set_i | input | 9 | Set written by the fill |
| fill_way_i | input | 2 | Way written by the fill |
| fill_ptag_i | input | 51 | Tag written by the fill |
| fill_dirty_i | input | 1 | Dirty state written by the fill |
| probe_set_i | input | 9 | Set read by the probe port |
| probe_way_i | input | 2 | Way read by the probe port |
| probe_valid_o | output | 1 | Valid bit of the probed entry |
| probe_dirty_o | output | 1 | Dirty bit of the probed entry |
| probe_ptag_o | output | 51 | Tag of the probed entry |

## Verification
The embedded assertions check these rules on every cycle:
- writeback payloads stay stable under back-pressure;
- a writeback appears only during a walk;
- done is a single pulse that coincides with busy falling;
- the set selector only holds or steps by one;
- refill writes never coincide with walk clears.

Only the bench's scenarios can show the following:
- which entries end up invalid and which survive;
- the order of writebacks across sets and ways;
- that stale invalid tags produce nothing;
- that starts and fills issued during a walk are ignored.

// File: rtl/alias_scrub_pkg.sv
package alias_scrub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WB   = 2'd2
  } walk_st_e;
endpackage

// File: rtl/alias_tag_store.sv
module alias_tag_store #(
  parameter int SETS_LOG2 = 9,
  parameter int WAYS      = 4,
  parameter int TAG_W     = 51,
  parameter int WAY_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_en,
  input  logic [SETS_LOG2-1:0]  fill_set,
  input  logic [WAY_W-1:0]      fill_way,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  fill_dirty,
  input  logic                  clr_en,
  input  logic [SETS_LOG2-1:0]  clr_set,
  input  logic [WAYS-1:0]       clr_mask,
  input  logic [SETS_LOG2-1:0]  wlk_set,
  output logic [WAYS-1:0]       wlk_valid,
  output logic [WAYS-1:0]       wlk_dirty,
  output logic [WAYS*TAG_W-1:0] wlk_tags,
  input  logic [SETS_LOG2-1:0]  prb_set,
  input  logic [WAY_W-1:0]      prb_way,
  output logic                  prb_valid,
  output logic                  prb_dirty,
  output logic [TAG_W-1:0]      prb_tag
);
  localparam int SETS = 1 << SETS_LOG2;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  // State bits: reset to invalid and clean
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else begin
      if (clr_en) begin
        vld_q[clr_set] <= vld_q[clr_set] & ~clr_mask;
        dty_q[clr_set] <= dty_q[clr_set] & ~clr_mask;
      end
      if (fill_en) begin
        vld_q[fill_set][fill_way] <= 1'b1;
        dty_q[fill_set][fill_way] <= fill_dirty;
      end
    end
  end

  // Tag payload carries no reset
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

  assign wlk_valid = vld_q[wlk_set];
  assign wlk_dirty = dty_q[wlk_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_wlk_rd
    assign wlk_tags[w*TAG_W +: TAG_W] = tag_q[wlk_set][w];
  end

  assign prb_valid = vld_q[prb_set][prb_way];
  assign prb_dirty = dty_q[prb_set][prb_way];
  assign prb_tag   = tag_q[prb_set][prb_way];

  AST_FILL_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && clr_en)); // R2
endmodule

// File: rtl/alias_way_match.sv
module alias_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 51,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS-1:0]       dirty,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      ref_tag,
  output logic [WAYS-1:0]       hit_mask,
  output logic                  dirty_hit,
  output logic [WAY_W-1:0]      pick_way
);
  logic [WAYS-1:0] dhit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_mask[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == ref_tag);
    assign dhit_vec[w] = hit_mask[w] && dirty[w];
  end

  assign dirty_hit = |dhit_vec;

  // Lowest-numbered dirty match wins
  always_comb begin
    pick_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (dhit_vec[w]) pick_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/alias_walk_ctrl.sv
module alias_walk_ctrl
  import alias_scrub_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int LOW_W = 7,
  parameter int SEL_W = 2,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_vidx,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [WAYS-1:0]  hit_mask,
  input  logic             dirty_hit,
  input  logic [WAY_W-1:0] pick_way,
  input  logic             wb_ready,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] walk_set,
  output logic [TAG_W-1:0] cur_tag,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_set,
  output logic [WAYS-1:0]  clr_mask,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_set,
  output logic [WAY_W-1:0] wb_way,
  output logic [TAG_W-1:0] wb_tag
);
  localparam logic [SEL_W-1:0] SEL_LAST = '1;

  walk_st_e         st_q;
  logic [SEL_W-1:0] sel_q;
  logic [LOW_W-1:0] low_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] wb_set_q;
  logic [WAY_W-1:0] wb_way_q;
  logic             done_q;

  assign walk_set = {sel_q, low_q};
  assign cur_tag  = tag_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign wb_valid = (st_q == ST_WB);
  assign wb_set   = wb_set_q;
  assign wb_way   = wb_way_q;
  assign wb_tag   = tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sel_q    <= '0;
      low_q    <= '0;
      tag_q    <= '0;
      wb_set_q <= '0;
      wb_way_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            low_q <= start_vidx[LOW_W-1:0];
            tag_q <= start_tag;
            sel_q <= '0;
            st_q  <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (dirty_hit) begin
            wb_set_q <= walk_set;
            wb_way_q <= pick_way;
            st_q     <= ST_WB;
          end else if (sel_q == SEL_LAST) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            sel_q <= sel_q + SEL_W'(1);
          end
        end
        ST_WB: begin
          if (wb_ready) st_q <= ST_WALK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Clean matches clear while walking; a dirty one clears on its handshake
  always_comb begin
    clr_en   = 1'b0;
    clr_set  = walk_set;
    clr_mask = '0;
    if (st_q == ST_WALK && !dirty_hit) begin
      clr_en   = |hit_mask;
      clr_mask = hit_mask;
    end else if (st_q == ST_WB && wb_ready) begin
      clr_en   = 1'b1;
      clr_set  = wb_set_q;
      clr_mask = WAYS'(1) << wb_way_q;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_set) && $stable(wb_way) && $stable(wb_tag))); // R7
  AST_WB_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (sel_q == $past(sel_q) || sel_q == $past(sel_q) + SEL_W'(1))); // R4
endmodule

// File: rtl/alias_scrub.sv
module alias_scrub #(
  parameter int PA_W       = 64,
  parameter int PAGE_OFF_W = 13,
  parameter int LINE_OFF_W = 6,
  parameter int IDX_W      = 9,
  parameter int WAYS       = 4,
  localparam int TAG_W     = PA_W - PAGE_OFF_W,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int LOW_W     = PAGE_OFF_W - LINE_OFF_W,
  localparam int SEL_W     = IDX_W - LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] miss_vidx_i,
  input  logic [TAG_W-1:0] miss_ptag_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wb_valid_o,
  input  logic             wb_ready_i,
  output logic [IDX_W-1:0] wb_set_o,
  output logic [WAY_W-1:0] wb_way_o,
  output logic [TAG_W-1:0] wb_ptag_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [TAG_W-1:0] fill_ptag_i,
  input  logic             fill_dirty_i,
  input  logic [IDX_W-1:0] probe_set_i,
  input  logic [WAY_W-1:0] probe_way_i,
  output logic             probe_valid_o,
  output logic             probe_dirty_o,
  output logic [TAG_W-1:0] probe_ptag_o
);
  logic [IDX_W-1:0]      walk_set;
  logic [TAG_W-1:0]      cur_tag;
  logic [WAYS-1:0]       wlk_valid;
  logic [WAYS-1:0]       wlk_dirty;
  logic [WAYS*TAG_W-1:0] wlk_tags;
  logic [WAYS-1:0]       hit_mask;
  logic                  dirty_hit;
  logic [WAY_W-1:0]      pick_way;
  logic                  clr_en;
  logic [IDX_W-1:0]      clr_set;
  logic [WAYS-1:0]       clr_mask;
  logic                  fill_ok;

  assign fill_ok = fill_en_i && !busy_o;

  alias_tag_store #(
    .SETS_LOG2(IDX_W), .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_ok), .fill_set(fill_set_i), .fill_way(fill_way_i),
    .fill_tag(fill_ptag_i), .fill_dirty(fill_dirty_i),
    .clr_en(clr_en), .clr_set(clr_set), .clr_mask(clr_mask),
    .wlk_set(walk_set), .wlk_valid(wlk_valid), .wlk_dirty(wlk_dirty), .wlk_tags(wlk_tags),
    .prb_set(probe_set_i), .prb_way(probe_way_i),
    .prb_valid(probe_valid_o), .prb_dirty(probe_dirty_o), .prb_tag(probe_ptag_o)
  );

  alias_way_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_match (
    .valid(wlk_valid), .dirty(wlk_dirty), .tags(wlk_tags), .ref_tag(cur_tag),
    .hit_mask(hit_mask), .dirty_hit(dirty_hit), .pick_way(pick_way)
  );

  alias_walk_ctrl #(
    .IDX_W(IDX_W), .LOW_W(LOW_W), .SEL_W(SEL_W),
    .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start_i), .start_vidx(miss_vidx_i), .start_tag(miss_ptag_i),
    .hit_mask(hit_mask), .dirty_hit(dirty_hit), .pick_way(pick_way),
    .wb_ready(wb_ready_i),
    .busy(busy_o), .done(done_o),
    .walk_set(walk_set), .cur_tag(cur_tag),
    .clr_en(clr_en), .clr_set(clr_set), .clr_mask(clr_mask),
    .wb_valid(wb_valid_o), .wb_set(wb_set_o), .wb_way(wb_way_o), .wb_tag(wb_ptag_o)
  );
endmodule

// File: tb/alias_scrub_tb.sv
module alias_scrub_tb;
  localparam int IDX_W = 9;
  localparam int WAY_W = 2;
  localparam int TAG_W = 51;
  localparam int WB_W  = IDX_W + WAY_W + TAG_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [IDX_W-1:0] miss_vidx_i = '0;
  logic [TAG_W-1:0] miss_ptag_i = '0;
  logic             busy_o, done_o, wb_valid_o;
  logic             wb_ready_i = 1'b0;
  logic [IDX_W-1:0] wb_set_o;
  logic [WAY_W-1:0] wb_way_o;
  logic [TAG_W-1:0] wb_ptag_o;
  logic             fill_en_i = 1'b0;
  logic [IDX_W-1:0] fill_set_i = '0;
  logic [WAY_W-1:0] fill_way_i = '0;
  logic [TAG_W-1:0] fill_ptag_i = '0;
  logic             fill_dirty_i = 1'b0;
  logic [IDX_W-1:0] probe_set_i = '0;
  logic [WAY_W-1:0] probe_way_i = '0;
  logic             probe_valid_o, probe_dirty_o;
  logic [TAG_W-1:0] probe_ptag_o;

  int total = 0;
  int bad = 0;
  int stall_reload = 0;
  int stall_cnt = 0;
  int wb_seen = 0;
  logic [WB_W-1:0] exp_q [$];

  bit              mv [int];
  bit              md [int];
  logic [TAG_W-1:0] mt [int];

  always #2.5 clk = ~clk;

  alias_scrub u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .miss_vidx_i(miss_vidx_i),
    .miss_ptag_i(miss_ptag_i), .busy_o(busy_o), .done_o(done_o),
    .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready_i), .wb_set_o(wb_set_o),
    .wb_way_o(wb_way_o), .wb_ptag_o(wb_ptag_o), .fill_en_i(fill_en_i),
    .fill_set_i(fill_set_i), .fill_way_i(fill_way_i), .fill_ptag_i(fill_ptag_i),
    .fill_dirty_i(fill_dirty_i), .probe_set_i(probe_set_i), .probe_way_i(probe_way_i),
    .probe_valid_o(probe_valid_o), .probe_dirty_o(probe_dirty_o), .probe_ptag_o(probe_ptag_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for the writeback channel, with programmable back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (wb_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected writeback", {wb_set_o, wb_way_o}, 64'h0);
          wb_ready_i = 1'b1;
        end else begin
          chk({wb_set_o, wb_way_o, wb_ptag_o} == exp_q[0], "R6/R7/R8 writeback payload",
              64'({wb_set_o, wb_way_o, wb_ptag_o[31:0]}), 64'({exp_q[0][WB_W-1:TAG_W], exp_q[0][31:0]}));
          if (stall_cnt > 0) begin
            wb_ready_i = 1'b0;
            stall_cnt--;
          end else begin
            wb_ready_i = 1'b1;
            void'(exp_q.pop_front());
            wb_seen++;
            stall_cnt = stall_reload;
          end
        end
      end else begin
        wb_ready_i = 1'b0;
      end
    end
  end

  initial begin
    #(100000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int key_of(input int set, input int way);
    return set * 4 + way;
  endfunction

  task automatic fill(input int set, input int way, input logic [TAG_W-1:0] tag, input bit dirty);
    @(negedge clk);
    fill_en_i = 1'b1; fill_set_i = IDX_W'(set); fill_way_i = WAY_W'(way);
    fill_ptag_i = tag; fill_dirty_i = dirty;
    if (!busy_o) begin
      mv[key_of(set, way)] = 1'b1; md[key_of(set, way)] = dirty; mt[key_of(set, way)] = tag;
    end
    @(negedge clk);
    fill_en_i = 1'b0;
  endtask

  task automatic probe(input int set, input int way, output logic v, output logic d, output logic [TAG_W-1:0] t);
    probe_set_i = IDX_W'(set); probe_way_i = WAY_W'(way);
    #1;
    v = probe_valid_o; d = probe_dirty_o; t = probe_ptag_o;
  endtask

  // Expected walk: sets {k, low} ascending, dirty matches lowest way first
  task automatic model_walk(input int low, input logic [TAG_W-1:0] tag);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 4; w++) begin
        int key;
        key = key_of(k * 128 + low, w);
        if (mv.exists(key) && mv[key] && mt[key] == tag) begin
          if (md[key]) exp_q.push_back({IDX_W'(k * 128 + low), WAY_W'(w), tag});
          mv[key] = 1'b0; md[key] = 1'b0;
        end
      end
    end
  endtask

  task automatic check_model(input string req);
    foreach (mv[key]) begin
      logic v, d;
      logic [TAG_W-1:0] t;
      probe(key / 4, key % 4, v, d, t);
      chk(v == mv[key] && d == md[key] && (!v || t == mt[key]), req,
          64'({v, d, t[31:0]}), 64'({mv[key], md[key], mt[key][31:0]}));
    end
  endtask

  task automatic run_walk(input int vidx, input logic [TAG_W-1:0] tag, output int busy_cyc, output int done_cnt);
    busy_cyc = 0; done_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; miss_vidx_i = IDX_W'(vidx); miss_ptag_i = tag;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (busy_o) busy_cyc++;
      if (done_o) begin
        done_cnt++;
        chk(!busy_o, "R9 done with busy low", 64'(busy_o), 64'h0);
        break;
      end
      @(negedge clk);
    end
  endtask

  localparam logic [TAG_W-1:0] TA = 51'h1_2345_6789_ABCD;
  localparam logic [TAG_W-1:0] TB = 51'h0_0BAD_F00D_0001;
  localparam logic [TAG_W-1:0] TC = 51'h7_FFFF_0000_1357;
  localparam logic [TAG_W-1:0] TD = 51'h2_2222_3333_4444;

  initial begin
    int bc, dc;
    logic v, d;
    logic [TAG_W-1:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!busy_o && !done_o && !wb_valid_o, "R1 outputs idle", 64'({busy_o, done_o, wb_valid_o}), 64'h0);
    probe(21, 1, v, d, t);
    chk(!v && !d, "R1 entry invalid", 64'({v, d}), 64'h0);
    probe(300, 3, v, d, t);
    chk(!v && !d, "R1 entry invalid", 64'({v, d}), 64'h0);

    // R2: fills read back; R4/R5: clean aliases cleared, others kept
    fill(0 * 128 + 21, 1, TA, 1'b0);
    fill(2 * 128 + 21, 0, TA, 1'b0);
    fill(2 * 128 + 21, 3, TB, 1'b0);
    fill(22, 0, TA, 1'b0);
    fill(3 * 128 + 21, 2, TB, 1'b1);
    check_model("R2 fill readback");
    model_walk(21, TA);
    run_walk(128 + 21, TA, bc, dc);
    chk(bc == 4, "R9 clean walk busy cycles", 64'(bc), 64'd4);
    chk(dc == 1, "R3 one done per start", 64'(dc), 64'd1);
    check_model("R5 clean alias clear / keep others");

    // R6/R7/R8/R4: dirty aliases with back-pressure
    stall_reload = 3; stall_cnt = 3; wb_seen = 0;
    fill(128 + 21, 2, TC, 1'b1);
    fill(128 + 21, 0, TC, 1'b1);
    fill(128 + 21, 1, TC, 1'b0);
    fill(3 * 128 + 21, 3, TC, 1'b1);
    model_walk(21, TC);
    run_walk(3 * 128 + 21, TC, bc, dc);
    chk(wb_seen == 3, "R6 writeback count", 64'(wb_seen), 64'd3);
    chk(exp_q.size() == 0, "R8 all expected writebacks seen", 64'(exp_q.size()), 64'h0);
    chk(bc > 4, "R7 walk stalls under back-pressure", 64'(bc), 64'd5);
    check_model("R6 dirty alias cleared after handshake");

    // R10: stale invalid entries with matching tag give nothing
    stall_reload = 0; stall_cnt = 0; wb_seen = 0;
    model_walk(21, TA);
    run_walk(21, TA, bc, dc);
    chk(wb_seen == 0, "R10 no writeback from stale tag", 64'(wb_seen), 64'h0);
    chk(bc == 4, "R10 walk length", 64'(bc), 64'd4);

    // R3/R2: start and fill during a walk are ignored
    fill(2 * 128 + 100, 1, TD, 1'b1);
    @(negedge clk);
    start_i = 1'b1; miss_vidx_i = IDX_W'(5); miss_ptag_i = TB;
    @(negedge clk);
    start_i = 1'b0;
    fill(100, 0, TD, 1'b1);
    @(negedge clk);
    start_i = 1'b1; miss_vidx_i = IDX_W'(100); miss_ptag_i = TD;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy_o, "R3 start while busy ignored", 64'(busy_o), 64'h0);
    probe(100, 0, v, d, t);
    chk(!v, "R2 fill while busy ignored", 64'(v), 64'h0);
    probe(2 * 128 + 100, 1, v, d, t);
    chk(v && d, "R3 ignored start did not walk", 64'({v, d}), 64'h3);
    chk(wb_seen == 0, "R3 no writeback from ignored start", 64'(wb_seen), 64'h0);

    // R5/R8: whole set of clean matches, upper vidx bits irrelevant (R4)
    for (int w = 0; w < 4; w++) fill(2 * 128 + 127, w, TB, 1'b0);
    fill(127, 2, TB, 1'b1);
    stall_reload = 1; stall_cnt = 1;
    model_walk(127, TB);
    run_walk(3 * 128 + 127, TB, bc, dc);
    chk(exp_q.size() == 0, "R4 writeback from set 0 seen", 64'(exp_q.size()), 64'h0);
    check_model("R5 full set cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule